// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Unit

This block carries out load-reserved (LR) and store-conditional (SC) requests for a core, one at a time, against a simple request/response memory port. It holds one address reservation. An LR that completes without error reads memory, records its address as the reservation and returns the loaded value sign-extended to register width. An SC compares its address with the reservation. It writes memory only when the two match, and returns a small code that tells the core whether the conditional store took effect.

Each request supplies an access size of 1, 2, 4 or 8 bytes, the base address, the store data, acquire/release ordering bits and a flag that reports a failed address translation. The block checks natural alignment first and then the translation flag. Faults are reported with a cause code and the faulting address, and no destination-register write takes place. The reservation is lost after any SC, on an invalidate pulse from outside and on reset.

Top module: `lrsc_unit`

## Requirements
- R1: Size encoding 0/1/2/3 means 1/2/4/8 bytes. An access is aligned when the address bits below log2(size in bytes) are all zero. A misaligned LR responds with cause 1 (load misaligned), makes no memory request and does not write rd.
- R2: A misaligned SC responds with cause 2 (store misaligned), makes no memory request and does not write rd.
- R3: An LR without fault returns the low size×8 bits of the read data, sign-extended to XLEN, with rd write enabled. Its address becomes the valid reservation. Read-data bits above the access size are ignored.
- R4: An SC whose address equals the valid reservation issues one write. The write carries the SC size and the low size×8 bits of the store data, zero-filled above. rd receives 0 when the memory reports the write done and 1 when it reports the write not done.
- R5: An SC with no valid reservation, or with an address different from the reservation, makes no memory request and writes 1 to rd.
- R6: Every accepted SC leaves the reservation invalid, whatever its outcome, including faults.
- R7: The LR read carries acquire = aq and release = aq AND rl. The SC write carries acquire = aq AND rl and release = rl.
- R8: A translation error (checked after alignment) or a memory error response gives cause 3 for LR and cause 4 for SC, leaves rd unwritten and does not set the reservation. A translation error makes no memory request.
- R9: An invalidate pulse, or reset, makes the reservation invalid. Invalidate takes precedence over an LR completing in the same cycle.
- R10: busy_o is high from the cycle after a request is accepted until its response completes. The memory request is held only while busy. rsp_valid_o is a one-cycle pulse, and any fault reports the request address. A size wider than XLEN/8 is illegal and is flagged by an assertion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when busy_o is low |
| req_sc_i | input | 1 | 0 = load-reserved, 1 = store-conditional |
| req_size_i | input | 2 | Access size code (R1) |
| req_addr_i | input | ADDR_W | Access address |
| req_data_i | input | XLEN | SC store data |
| req_aq_i | input | 1 | Acquire bit of the request |
| req_rl_i | input | 1 | Release bit of the request |
| req_xlate_err_i | input | 1 | Address translation failed for this request |
| inval_i | input | 1 | Drops the reservation |
| busy_o | output | 1 | A request is in progress |
| mem_req_o | output | 1 | Memory request, held until a response arrives |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_size_o | output | 2 | Memory access size code |
| mem_wdata_o | output | XLEN | Write data, low size×8 bits valid |
| mem_acq_o | output | 1 | Acquire ordering to memory |
| mem_rel_o | output | 1 | Release ordering to memory |
| mem_rsp_valid_i | input | 1 | Memory response strobe |
| mem_err_i | input | 1 | Memory access raised an exception |
| mem_wr_ok_i | input | 1 | Write took effect |
| mem_rdata_i | input | XLEN | Read data, low-aligned |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rd_we_o | output | 1 | rd is to be written |
| rsp_rd_data_o | output | XLEN | Value for rd |
| rsp_cause_o | output | 3 | 0 none, 1 load misaligned, 2 store misaligned, 3 load access, 4 store access |
| rsp_fault_addr_o | output | ADDR_W | Faulting address |

## Verification
On every cycle the assertions check the following. The memory request stays stable and stays inside busy. The response is a single pulse. A fault never comes with an rd write, and a misaligned response never follows a memory request. Any SC acceptance or invalidate pulse leaves the reservation invalid, a clean LR completion leaves it valid, and the ordering bits seen at the port satisfy the read and write combinations. The values themselves can only be shown by the bench's ordered scenarios. These are the sign-extended results and masked write data, the 0/1 success codes, the distinction between matching and mismatching addresses, and the loss of the reservation after a faulting SC, an invalidate or a reset.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } lrsc_state_e;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_LD_MISAL = 3'd1,
    CAUSE_ST_MISAL = 3'd2,
    CAUSE_LD_ACC   = 3'd3,
    CAUSE_ST_ACC   = 3'd4
  } lrsc_cause_e;

  localparam int NUM_SIZES = 4;
endpackage

// File: rtl/lrsc_align_chk.sv
module lrsc_align_chk (
  input  logic [2:0] addr_lo_i,
  input  logic [1:0] size_i,
  output logic       misal_o
);
  logic [2:0] lo_mask;

  always_comb begin
    case (size_i)
      2'd0:    lo_mask = 3'b000;
      2'd1:    lo_mask = 3'b001;
      2'd2:    lo_mask = 3'b011;
      default: lo_mask = 3'b111;
    endcase
    misal_o = |(addr_lo_i & lo_mask);
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [ADDR_W-1:0] set_addr_i,
  input  logic              clr_i,
  input  logic              inval_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic              match_o,
  output logic              valid_o
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  // clear sources win over a set in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (clr_i || inval_i) begin
      vld_q  <= 1'b0;
    end else if (set_i) begin
      vld_q  <= 1'b1;
      addr_q <= set_addr_i;
    end
  end

  assign match_o = vld_q && (addr_q == chk_addr_i);
  assign valid_o = vld_q;
endmodule

// File: rtl/lrsc_data_fmt.sv
module lrsc_data_fmt import lrsc_pkg::*; #(
  parameter int XLEN = 64
) (
  input  logic [1:0]      ld_size_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [1:0]      st_size_i,
  input  logic [XLEN-1:0] wsrc_i,
  output logic [XLEN-1:0] ld_ext_o,
  output logic [XLEN-1:0] st_data_o
);
  logic [XLEN-1:0] ext_by_sz [NUM_SIZES];
  logic [XLEN-1:0] wr_by_sz  [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_sz
    localparam int W = ((8 << g) < XLEN) ? (8 << g) : XLEN;
    if (W < XLEN) begin : g_part
      assign ext_by_sz[g] = {{(XLEN-W){rdata_i[W-1]}}, rdata_i[W-1:0]};
      assign wr_by_sz[g]  = {{(XLEN-W){1'b0}}, wsrc_i[W-1:0]};
    end else begin : g_full
      assign ext_by_sz[g] = rdata_i;
      assign wr_by_sz[g]  = wsrc_i;
    end
  end

  assign ld_ext_o  = ext_by_sz[ld_size_i];
  assign st_data_o = wr_by_sz[st_size_i];
endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit import lrsc_pkg::*; #(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_sc_i,
  input  logic [1:0]        req_size_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [XLEN-1:0]   req_data_i,
  input  logic              req_aq_i,
  input  logic              req_rl_i,
  input  logic              req_xlate_err_i,
  input  logic              inval_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              mem_acq_o,
  output logic              mem_rel_o,
  input  logic              mem_rsp_valid_i,
  input  logic              mem_err_i,
  input  logic              mem_wr_ok_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  output logic              rsp_valid_o,
  output logic              rsp_rd_we_o,
  output logic [XLEN-1:0]   rsp_rd_data_o,
  output logic [2:0]        rsp_cause_o,
  output logic [ADDR_W-1:0] rsp_fault_addr_o
);
  localparam logic [XLEN-1:0] SC_FAIL = XLEN'(1);

  lrsc_state_e       state_q;
  lrsc_cause_e       cause_q;
  logic              sc_q;
  logic [1:0]        size_q;
  logic [ADDR_W-1:0] addr_q;
  logic [XLEN-1:0]   wdata_q;
  logic              acq_q, rel_q;
  logic              rd_we_q;
  logic [XLEN-1:0]   rd_q;

  logic              accept;
  logic              misal;
  logic              resv_match;
  logic              resv_vld;
  logic              resv_set;
  logic [XLEN-1:0]   ld_ext;
  logic [XLEN-1:0]   st_data;

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign resv_set = (state_q == ST_MEM) && mem_rsp_valid_i && !mem_err_i && !sc_q;

  lrsc_align_chk u_align (
    .addr_lo_i (req_addr_i[2:0]),
    .size_i    (req_size_i),
    .misal_o   (misal)
  );

  lrsc_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (resv_set),
    .set_addr_i (addr_q),
    .clr_i      (accept && req_sc_i),
    .inval_i    (inval_i),
    .chk_addr_i (req_addr_i),
    .match_o    (resv_match),
    .valid_o    (resv_vld)
  );

  lrsc_data_fmt #(.XLEN(XLEN)) u_fmt (
    .ld_size_i (size_q),
    .rdata_i   (mem_rdata_i),
    .st_size_i (req_size_i),
    .wsrc_i    (req_data_i),
    .ld_ext_o  (ld_ext),
    .st_data_o (st_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      sc_q    <= 1'b0;
      size_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      acq_q   <= 1'b0;
      rel_q   <= 1'b0;
      rd_we_q <= 1'b0;
      rd_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          sc_q    <= req_sc_i;
          size_q  <= req_size_i;
          addr_q  <= req_addr_i;
          wdata_q <= st_data;
          acq_q   <= req_sc_i ? (req_aq_i && req_rl_i) : req_aq_i;
          rel_q   <= req_sc_i ? req_rl_i : (req_aq_i && req_rl_i);
          rd_we_q <= 1'b0;
          rd_q    <= '0;
          cause_q <= CAUSE_NONE;
          if (misal) begin
            cause_q <= req_sc_i ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
            state_q <= ST_RESP;
          end else if (req_xlate_err_i) begin
            cause_q <= req_sc_i ? CAUSE_ST_ACC : CAUSE_LD_ACC;
            state_q <= ST_RESP;
          end else if (req_sc_i && !resv_match) begin
            rd_we_q <= 1'b1;
            rd_q    <= SC_FAIL;
            state_q <= ST_RESP;
          end else begin
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_rsp_valid_i) begin
          state_q <= ST_RESP;
          if (mem_err_i) begin
            cause_q <= sc_q ? CAUSE_ST_ACC : CAUSE_LD_ACC;
          end else begin
            rd_we_q <= 1'b1;
            rd_q    <= sc_q ? (mem_wr_ok_i ? '0 : SC_FAIL) : ld_ext;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o           = (state_q != ST_IDLE);
  assign mem_req_o        = (state_q == ST_MEM);
  assign mem_we_o         = sc_q;
  assign mem_addr_o       = addr_q;
  assign mem_size_o       = size_q;
  assign mem_wdata_o      = wdata_q;
  assign mem_acq_o        = acq_q;
  assign mem_rel_o        = rel_q;
  assign rsp_valid_o      = (state_q == ST_RESP);
  assign rsp_rd_we_o      = rd_we_q;
  assign rsp_rd_data_o    = rd_q;
  assign rsp_cause_o      = cause_q;
  assign rsp_fault_addr_o = addr_q;
endmodule

// File: rtl/lrsc_unit_chk.sv
module lrsc_unit_chk #(
  parameter int XLEN   = 64,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_sc_i,
  input logic [1:0]        req_size_i,
  input logic              inval_i,
  input logic              busy_o,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_acq_o,
  input logic              mem_rel_o,
  input logic              mem_rsp_valid_i,
  input logic              mem_err_i,
  input logic              rsp_valid_o,
  input logic              rsp_rd_we_o,
  input logic [2:0]        rsp_cause_o,
  input logic              resv_vld
);
  localparam int XBYTES = XLEN / 8;

  p_size_fits_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o |-> (32'd1 << req_size_i) <= XBYTES);

  p_mem_in_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  p_mem_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rsp_valid_i |=> mem_req_o && $stable(mem_addr_o));

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_fault_no_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_cause_o != 3'd0 |-> !rsp_rd_we_o);

  p_misal_no_mem_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (rsp_cause_o == 3'd1 || rsp_cause_o == 3'd2) |-> !$past(mem_req_o));

  p_rd_ord_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_rel_o |-> mem_acq_o);

  p_wr_ord_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o && mem_acq_o |-> mem_rel_o);

  p_sc_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !busy_o && req_sc_i |=> !resv_vld);

  p_inval_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !resv_vld);

  p_lr_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_rsp_valid_i && !mem_we_o && !mem_err_i && !inval_i |=> resv_vld);
endmodule

bind lrsc_unit lrsc_unit_chk #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_sc_i        (req_sc_i),
  .req_size_i      (req_size_i),
  .inval_i         (inval_i),
  .busy_o          (busy_o),
  .mem_req_o       (mem_req_o),
  .mem_we_o        (mem_we_o),
  .mem_addr_o      (mem_addr_o),
  .mem_acq_o       (mem_acq_o),
  .mem_rel_o       (mem_rel_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_err_i       (mem_err_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_rd_we_o     (rsp_rd_we_o),
  .rsp_cause_o     (rsp_cause_o),
  .resv_vld        (resv_vld)
);

// File: tb/lrsc_unit_tb.sv
module lrsc_unit_tb;
  localparam int XLEN   = 64;
  localparam int ADDR_W = 32;

  typedef struct packed {
    logic        sc;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [63:0] data;
    logic        aq;
    logic        rl;
    logic        xerr;
    logic [63:0] rdat;
    logic        merr;
    logic        wok;
    logic        emem;
    logic        ewe;
    logic [63:0] erd;
    logic [2:0]  ecause;
  } vec_t;

  localparam int NV = 20;
  // sc sz addr data aq rl xerr rdat merr wok | emem ewe erd ecause
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h100, 64'h0, 1'b1, 1'b1, 1'b0, 64'h0000_0000_8000_0001, 1'b0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_8000_0001, 3'd0},
    '{1'b1, 2'd2, 32'h100, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 3'd0},
    '{1'b1, 2'd2, 32'h100, 64'h5, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b0, 2'd0, 32'h203, 64'h0, 1'b0, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 1'b0, 1'b0, 1'b1, 1'b1, 64'h7F, 3'd0},
    '{1'b1, 2'd0, 32'h204, 64'hAB, 1'b1, 1'b1, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b1, 2'd0, 32'h203, 64'hAB, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b0, 2'd1, 32'h301, 64'h0, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 3'd1},
    '{1'b0, 2'd3, 32'h408, 64'h0, 1'b0, 1'b0, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 64'h8000_0000_0000_0000, 3'd0},
    '{1'b1, 2'd3, 32'h40C, 64'h1, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 3'd2},
    '{1'b1, 2'd3, 32'h408, 64'h1, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b0, 2'd1, 32'h502, 64'h0, 1'b1, 1'b0, 1'b0, 64'h0000_0000_FFFF_8123, 1'b0, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_8123, 3'd0},
    '{1'b1, 2'd1, 32'h502, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 1'b1, 1'b0, 64'h0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h1, 3'd0},
    '{1'b0, 2'd2, 32'h600, 64'h0, 1'b0, 1'b0, 1'b1, 64'h0, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 3'd3},
    '{1'b0, 2'd2, 32'h600, 64'h0, 1'b0, 1'b0, 1'b0, 64'h1, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 3'd3},
    '{1'b1, 2'd2, 32'h600, 64'h9, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b0, 2'd2, 32'h700, 64'h0, 1'b0, 1'b0, 1'b0, 64'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 64'h1234_5678, 3'd0},
    '{1'b1, 2'd2, 32'h700, 64'h9, 1'b0, 1'b1, 1'b0, 64'h0, 1'b1, 1'b0, 1'b1, 1'b0, 64'h0, 3'd4},
    '{1'b1, 2'd2, 32'h700, 64'h9, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0},
    '{1'b1, 2'd2, 32'h702, 64'h9, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 3'd2},
    '{1'b1, 2'd2, 32'h800, 64'h9, 1'b0, 1'b0, 1'b1, 64'h0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 3'd4}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_sc = 1'b0, req_aq = 1'b0, req_rl = 1'b0, req_xerr = 1'b0;
  logic [1:0]        req_size = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [XLEN-1:0]   req_data = '0;
  logic              inval = 1'b0;
  logic              busy, mem_req, mem_we, mem_acq, mem_rel;
  logic [ADDR_W-1:0] mem_addr;
  logic [1:0]        mem_size;
  logic [XLEN-1:0]   mem_wdata;
  logic              mem_rsp_valid = 1'b0, mem_err = 1'b0, mem_wr_ok = 1'b0;
  logic [XLEN-1:0]   mem_rdata = '0;
  logic              rsp_valid, rsp_we;
  logic [XLEN-1:0]   rsp_data;
  logic [2:0]        rsp_cause;
  logic [ADDR_W-1:0] rsp_faddr;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  lrsc_unit #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_sc_i(req_sc), .req_size_i(req_size),
    .req_addr_i(req_addr), .req_data_i(req_data), .req_aq_i(req_aq), .req_rl_i(req_rl),
    .req_xlate_err_i(req_xerr), .inval_i(inval), .busy_o(busy),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_acq_o(mem_acq), .mem_rel_o(mem_rel),
    .mem_rsp_valid_i(mem_rsp_valid), .mem_err_i(mem_err), .mem_wr_ok_i(mem_wr_ok),
    .mem_rdata_i(mem_rdata), .rsp_valid_o(rsp_valid), .rsp_rd_we_o(rsp_we),
    .rsp_rd_data_o(rsp_data), .rsp_cause_o(rsp_cause), .rsp_fault_addr_o(rsp_faddr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int idx);
    logic        got_mem;
    logic [63:0] mask;
    logic        eacq, erel;
    mask = (v.sz == 2'd3) ? '1 : ((64'd1 << (8 << v.sz)) - 64'd1);
    eacq = v.sc ? (v.aq & v.rl) : v.aq;
    erel = v.sc ? v.rl : (v.aq & v.rl);
    @(negedge clk);
    req_valid = 1'b1; req_sc = v.sc; req_size = v.sz; req_addr = v.addr;
    req_data = v.data; req_aq = v.aq; req_rl = v.rl; req_xerr = v.xerr;
    @(negedge clk);
    req_valid = 1'b0;
    got_mem = mem_req;
    chk(busy, $sformatf("R10 busy v%0d", idx), 64'(busy), 64'd1);
    chk(got_mem == v.emem, $sformatf("R1 R2 R5 R8 mem_req v%0d", idx), 64'(got_mem), 64'(v.emem));
    if (got_mem) begin
      if (v.emem) begin
        chk(mem_we == v.sc && mem_addr == v.addr && mem_size == v.sz,
            $sformatf("R4 cmd v%0d", idx), {31'd0, mem_we, mem_addr}, {31'd0, v.sc, v.addr});
        chk(mem_acq == eacq && mem_rel == erel, $sformatf("R7 order v%0d", idx),
            {62'd0, mem_acq, mem_rel}, {62'd0, eacq, erel});
        if (v.sc) chk(mem_wdata == (v.data & mask), $sformatf("R4 wdata v%0d", idx),
                      mem_wdata, v.data & mask);
      end
      mem_rsp_valid = 1'b1; mem_rdata = v.rdat; mem_err = v.merr; mem_wr_ok = v.wok;
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_err = 1'b0;
    end
    chk(rsp_valid, $sformatf("R10 rsp v%0d", idx), 64'(rsp_valid), 64'd1);
    chk(rsp_we == v.ewe, $sformatf("R8 rd_we v%0d", idx), 64'(rsp_we), 64'(v.ewe));
    if (v.ewe) chk(rsp_data == v.erd, $sformatf("R3 R4 R5 R6 rd v%0d", idx), rsp_data, v.erd);
    chk(rsp_cause == v.ecause, $sformatf("R1 R2 R8 cause v%0d", idx), 64'(rsp_cause), 64'(v.ecause));
    if (v.ecause != 3'd0)
      chk(rsp_faddr == v.addr, $sformatf("R10 fault addr v%0d", idx), 64'(rsp_faddr), 64'(v.addr));
    @(negedge clk);
    chk(!rsp_valid && !busy, $sformatf("R10 idle v%0d", idx), {62'd0, rsp_valid, busy}, 64'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req && !busy, "R10 reset state", {61'd0, rsp_valid, mem_req, busy}, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run(VECS[i], i);

    // R9: invalidate pulse drops the reservation
    v = '{1'b0, 2'd2, 32'h800, 64'h0, 1'b0, 1'b0, 1'b0, 64'h42, 1'b0, 1'b0, 1'b1, 1'b1, 64'h42, 3'd0};
    run(v, 100);
    @(negedge clk); inval = 1'b1;
    @(negedge clk); inval = 1'b0;
    v = '{1'b1, 2'd2, 32'h800, 64'h7, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0};
    run(v, 101);

    // control: matching SC succeeds with code 0 (R4)
    v = '{1'b0, 2'd3, 32'h900, 64'h0, 1'b0, 1'b0, 1'b0, 64'h5, 1'b0, 1'b0, 1'b1, 1'b1, 64'h5, 3'd0};
    run(v, 102);
    v = '{1'b1, 2'd3, 32'h900, 64'hDEAD_BEEF_0000_0001, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 3'd0};
    run(v, 103);

    // R9: reset drops the reservation
    v = '{1'b0, 2'd3, 32'h900, 64'h0, 1'b0, 1'b0, 1'b0, 64'h5, 1'b0, 1'b0, 1'b1, 1'b1, 64'h5, 3'd0};
    run(v, 104);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    v = '{1'b1, 2'd3, 32'h900, 64'h3, 1'b0, 1'b0, 1'b0, 64'h0, 1'b0, 1'b1, 1'b0, 1'b1, 64'h1, 3'd0};
    run(v, 105);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule